// File: doc/BRIEF.md
# Dual-Mode Serial Transmit Formatter

This block turns one byte from a transmit data port into a serial stream. An 8-bit configuration register decides how the byte goes out. In framed (asynchronous) mode the block sends a low start bit, 7 or 8 data bits, an optional parity bit and one or two high stop bits. Each bit lasts a fixed number of ticks of a prescaled clock. In clocked (synchronous) mode the block sends exactly 8 data bits with no framing, together with a shift clock that the receiver uses to sample them.

Software can write and read the configuration register at any cycle. A transfer uses the settings that were in the register when its byte was accepted, so a change made mid-character first applies to the next character. Bytes are offered with a valid/ready handshake, and the block takes a byte only while it is idle. Data always leaves least significant bit first.

Top module: `sertx_fmt`

## Requirements
- R1: The configuration register resets to 0x00 and reads back the last written value in the cycle after the write, including during a transfer. Bit 2 is stored but has no effect on the output.
- R2: With bit 7 = 0 (framed mode), a character is a start bit at 0, then the data bits LSB first, then stop bits at 1. Bit 3 selects one stop bit (0) or two stop bits (1).
- R3: In framed mode, bit 6 = 1 selects 7-bit characters, and data bit 7 is then not sent. Bit 6 = 0 selects 8-bit characters.
- R4: In framed mode, bit 5 = 1 inserts a parity bit right after the data bits. Bit 4 sets its sense: 0 makes the count of ones over the sent data bits and the parity bit even, and 1 makes it odd.
- R5: With bit 7 = 1 (clocked mode), a character is exactly 8 data bits, LSB first, with no start, parity or stop bits. Bits 6, 5, 4 and 3 have no effect in this mode.
- R6: Bits 1:0 = k give a divided tick of 4^k input clocks. In framed mode each bit lasts 16 ticks. In clocked mode each bit lasts 2 ticks.
- R7: In clocked mode the shift clock is low for the first tick of each bit and high for the second tick. The shift clock is high at all other times, including during framed transfers. The data output changes only where the shift clock falls.
- R8: A byte is accepted on a clock edge where tx_valid and tx_ready are both high. tx_ready is low while busy, and tx_valid is ignored during that time.
- R9: A configuration write made during a transfer leaves the character in progress unchanged and applies to the next character.
- R10: The serial output is high and busy is low when idle. Busy rises on the accepting edge and falls on the edge that ends the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Configuration register write strobe |
| reg_wdata | input | 8 | Configuration write data |
| reg_rdata | output | 8 | Configuration register contents |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Block can accept a byte |
| ser_out | output | 1 | Serial data line |
| sclk_out | output | 1 | Shift clock (clocked mode) |
| busy | output | 1 | A character is being sent |

## Verification
Random configuration and data pairs are sent, and the serial line and shift clock are sampled twice in every bit period. The random configurations cover both modes, both character lengths, parity off, even and odd, both stop counts and three prescaler settings. Comparing the samples against a bench model separates mistakes in bit order, dropped or extra bits, parity sense and bit duration. Directed cases add:
- the slowest prescaler;
- clocked mode with the framing bits set, showing that they are overridden;
- a configuration write in the middle of a character, showing the settings are latched per character;
- a byte offered while busy, showing that it is ignored.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int FRAME_W = 12;
  localparam int LEN_W   = 4;

  // configuration bit positions
  localparam int CFG_SYNC  = 7;
  localparam int CFG_CHR7  = 6;
  localparam int CFG_PEN   = 5;
  localparam int CFG_ODD   = 4;
  localparam int CFG_STOP2 = 3;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [LEN_W-1:0]   len;
  } frame_t;

  function automatic logic calc_parity(input logic [7:0] d, input logic chr7,
                                       input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < 8; i++) begin
      if (!(chr7 && i == 7)) p = p ^ d[i];
    end
    return p;
  endfunction

  function automatic frame_t build_frame(input logic [7:0] cfg, input logic [7:0] d);
    frame_t f;
    int     n;
    f.bits = '1;
    n = 0;
    if (cfg[CFG_SYNC]) begin
      f.bits[7:0] = d;
      n = 8;
    end else begin
      f.bits[0] = 1'b0;
      n = 1;
      for (int i = 0; i < 8; i++) begin
        if (!(cfg[CFG_CHR7] && i == 7)) begin
          f.bits[n] = d[i];
          n = n + 1;
        end
      end
      if (cfg[CFG_PEN]) begin
        f.bits[n] = calc_parity(d, cfg[CFG_CHR7], cfg[CFG_ODD]);
        n = n + 1;
      end
      n = n + (cfg[CFG_STOP2] ? 2 : 1);
    end
    f.len = LEN_W'(n);
    return f;
  endfunction

  // clocks per divided tick
  function automatic int unsigned tick_clocks(input logic [1:0] sel, input int step_log);
    return 32'd1 << (step_log * int'(sel));
  endfunction

  // clocks per serial bit
  function automatic int unsigned bit_clocks(input logic [7:0] cfg, input int ovs,
                                             input int step_log);
    int unsigned t;
    t = tick_clocks(cfg[1:0], step_log);
    return cfg[CFG_SYNC] ? 2 * t : ovs * t;
  endfunction

endpackage

// File: rtl/sertx_cfgreg.sv
module sertx_cfgreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cfg <= '0;
    else if (we) cfg <= wdata;
  end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int STEP_LOG = 2,
  parameter int CNT_W    = 11
) (
  input  logic [7:0]       cfg,
  input  logic [7:0]       data,
  output frame_t           frame,
  output logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] half
);
  always_comb begin
    frame = build_frame(cfg, data);
    per   = CNT_W'(bit_clocks(cfg, OVS, STEP_LOG));
    half  = CNT_W'(tick_clocks(cfg[1:0], STEP_LOG));
  end
endmodule

// File: rtl/sertx_bittimer.sv
module sertx_bittimer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] per_in,
  input  logic [CNT_W-1:0] half_in,
  output logic             bit_end,
  output logic             low_half
);
  logic [CNT_W-1:0] cnt, per_q, half_q;

  assign bit_end  = run && (cnt == '0);
  assign low_half = run && (cnt >= half_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      per_q  <= '0;
      half_q <= '0;
    end else if (load) begin
      cnt    <= per_in - 1'b1;
      per_q  <= per_in;
      half_q <= half_in;
    end else if (run) begin
      cnt <= (cnt == '0) ? per_q - 1'b1 : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sertx_fmt.sv
module sertx_fmt
  import sertx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int STEP_LOG = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       ser_out,
  output logic       sclk_out,
  output logic       busy
);
  localparam int MAX_PER = OVS << (STEP_LOG * 3);
  localparam int CNT_W   = $clog2(MAX_PER) + 1;

  logic [7:0]         cfg;
  frame_t             frm;
  logic [CNT_W-1:0]   per, half;
  logic               accept, bit_end, low_half, cur_sync;
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   left;

  sertx_cfgreg #(.W(8)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .cfg(cfg)
  );

  sertx_framer #(.OVS(OVS), .STEP_LOG(STEP_LOG), .CNT_W(CNT_W)) u_frm (
    .cfg(cfg), .data(tx_data), .frame(frm), .per(per), .half(half)
  );

  sertx_bittimer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(accept), .run(busy),
    .per_in(per), .half_in(half), .bit_end(bit_end), .low_half(low_half)
  );

  assign accept    = tx_valid && !busy;
  assign tx_ready  = !busy;
  assign reg_rdata = cfg;
  assign ser_out   = busy ? shreg[0] : 1'b1;
  assign sclk_out  = !(busy && cur_sync && low_half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      shreg    <= '1;
      left     <= '0;
      cur_sync <= 1'b0;
    end else if (accept) begin
      busy     <= 1'b1;
      shreg    <= frm.bits;
      left     <= frm.len;
      cur_sync <= cfg[CFG_SYNC];
    end else if (bit_end) begin
      if (left == LEN_W'(1)) busy <= 1'b0;
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      left  <= left - 1'b1;
    end
  end
endmodule

// File: rtl/sertx_fmt_chk.sv
module sertx_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       tx_valid,
  input logic       busy,
  input logic       ser_out,
  input logic       sclk_out,
  input logic       cur_sync
);
  AST_REG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we) |-> reg_rdata == $past(reg_wdata)); // R1

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !cur_sync |-> !ser_out); // R2

  AST_ASYNC_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cur_sync |-> sclk_out); // R7

  AST_SYNC_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && cur_sync && !$fell(sclk_out) |-> $stable(ser_out)); // R7

  AST_ACCEPT_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_valid)); // R8

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cur_sync)); // R9

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_out && sclk_out); // R10
endmodule

bind sertx_fmt sertx_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .tx_valid(tx_valid), .busy(busy),
  .ser_out(ser_out), .sclk_out(sclk_out), .cur_sync(cur_sync)
);

// File: tb/sertx_fmt_test.sv
module sertx_fmt_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready, ser_out, sclk_out, busy;

  int checks = 0;
  int errors = 0;
  logic [7:0] cur_cfg = '0;

  always #10 clk = ~clk;

  sertx_fmt uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .ser_out(ser_out), .sclk_out(sclk_out), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model of the character
  function automatic int exp_len(input logic [7:0] c);
    if (c[7]) return 8;
    return 1 + (c[6] ? 7 : 8) + (c[5] ? 1 : 0) + (c[3] ? 2 : 1);
  endfunction

  function automatic logic exp_bit(input logic [7:0] c, input logic [7:0] d, input int i);
    int dl;
    int ones;
    if (c[7]) return d[i];
    dl = c[6] ? 7 : 8;
    if (i == 0) return 1'b0;
    if (i <= dl) return d[i-1];
    if (c[5] && i == dl + 1) begin
      ones = $countones(c[6] ? {1'b0, d[6:0]} : d);
      return ((ones % 2) == 1) ^ c[4];
    end
    return 1'b1;
  endfunction

  function automatic int exp_per(input logic [7:0] c);
    int t;
    t = 1;
    for (int k = 0; k < int'(c[1:0]); k++) t = t * 4;
    return c[7] ? 2 * t : 16 * t;
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    cur_cfg = v;
    check("R1 readback", reg_rdata, v);
  endtask

  task automatic send(input logic [7:0] d, input bit mid, input logic [7:0] mid_cfg,
                      input bit poke);
    logic [7:0] c;
    int n, p;
    c = cur_cfg;
    n = exp_len(c);
    p = exp_per(c);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = d;
    @(posedge clk);
    #1;
    tx_valid = 1'b0;
    check("R8 busy after accept", busy, 1);
    check("R8 ready low", tx_ready, 0);
    if (mid) begin
      fork
        begin
          repeat (2) @(negedge clk);
          reg_we = 1'b1;
          reg_wdata = mid_cfg;
          @(negedge clk);
          reg_we = 1'b0;
        end
      join_none
    end
    if (poke) begin
      fork
        begin
          repeat (2) @(negedge clk);
          tx_valid = 1'b1;
          tx_data = ~d;
          @(negedge clk);
          tx_valid = 1'b0;
        end
      join_none
    end
    for (int i = 0; i < n; i++) begin
      repeat (p / 2) @(negedge clk);
      check(c[7] ? "R5 sync data" : "R2 R3 R4 framed data", ser_out, exp_bit(c, d, i));
      check("R7 sclk first half", sclk_out, c[7] ? 0 : 1);
      @(negedge clk);
      check("R6 data held", ser_out, exp_bit(c, d, i));
      check("R7 sclk second half", sclk_out, 1);
      repeat (p / 2 - 1) @(negedge clk);
    end
    check("R6 R10 busy to last bit", busy, 1);
    @(negedge clk);
    check("R10 busy falls", busy, 0);
    check("R10 idle line", ser_out, 1);
    if (mid) begin
      check("R9 new cfg visible", reg_rdata, mid_cfg);
      cur_cfg = mid_cfg;
    end
    if (poke) begin
      repeat (5) @(negedge clk);
      check("R8 poked byte ignored", busy, 0);
      check("R8 line idle", ser_out, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rc, rd;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset value", reg_rdata, 8'h00);
    check("R10 reset idle", ser_out, 1);
    check("R7 reset sclk", sclk_out, 1);
    check("R8 reset ready", tx_ready, 1);
    // directed corners
    send(8'hA5, 0, 8'h00, 0);            // R2 8N1
    write_cfg(8'h48); send(8'hC3, 0, 8'h00, 0);   // R3 7 bits, 2 stop
    write_cfg(8'h20); send(8'h07, 0, 8'h00, 0);   // R4 even
    write_cfg(8'h30); send(8'h07, 0, 8'h00, 0);   // R4 odd
    write_cfg(8'h70); send(8'hFF, 0, 8'h00, 0);   // R3 R4 7-bit odd
    write_cfg(8'hF9); send(8'h96, 0, 8'h00, 0);   // R5 framing bits ignored
    write_cfg(8'h04); send(8'h3C, 0, 8'h00, 0);   // R1 mp bit stored
    write_cfg(8'h03); send(8'h5A, 0, 8'h00, 0);   // R6 slowest
    write_cfg(8'h00); send(8'h81, 1, 8'h80, 0);   // R9 change mid-char
    send(8'h81, 0, 8'h00, 1);                     // R9 sync next, R8 poke
    // random
    for (int k = 0; k < 40; k++) begin
      rc = 8'($urandom);
      if (rc[1:0] == 2'b11) rc[1:0] = 2'b10;
      rd = 8'($urandom);
      write_cfg(rc);
      send(rd, 0, 8'h00, (k % 7) == 3);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule